// File: doc/BRIEF.md
# RTC Interrupt Status and Request Logic

This block keeps the three interrupt flags of a real-time clock: the update-ended flag, the alarm flag and the periodic flag. It also drives the combined interrupt request pin. Each flag is set by its own event. The update-ended flag follows a strobe from the time-keeping logic. The alarm flag follows a pulse from the alarm comparator. The periodic flag follows a transition on the selected divider-chain tap, and that tap is synchronized and edge-detected inside the block.

A read of the status register returns the request bit, the three flags and four zero bits. The read also clears the flags on the following clock edge. The periodic and update-ended flags are held clear during an RTC reset (hardware or software) and while the RTC is disabled. The alarm flag is held clear while the supply-valid indication is low, so that an alarm taken from unreliable time never reaches software.

The request pin is the OR of each flag ANDed with its enable. The update-ended enable is masked while the RTC is held in reset or disabled.

Top module: `rtc_irq_status`

## Requirements
- R1: After hardware reset (`rst_n` low) all three flags are 0, `stat_rdata` reads 0x00 and `irq` is 0.
- R2: A one-cycle `upd_done` pulse sets the update-ended flag. The flag is visible at `stat_rdata` bit 4 one clock after the pulse.
- R3: A one-cycle `alarm_hit` pulse sets the alarm flag when `supply_ok` is 1. The flag is visible at `stat_rdata` bit 5 one clock after the pulse.
- R4: With the default rising-edge mode, a 0-to-1 change of `div_tap` sets the periodic flag at `stat_rdata` bit 6. The flag appears SYNC_STAGES+1 clocks after the change. A 1-to-0 change does not set the flag.
- R5: Bits 3:0 of `stat_rdata` always read 0.
- R6: `irq` and `stat_rdata` bit 7 equal (`upd_ie` and update flag) or (`alm_ie` and alarm flag) or (`per_ie` and periodic flag). A flag whose enable is 0 does not raise `irq`.
- R7: In the cycle `stat_rd` is 1, `stat_rdata` shows the flag values from before the clear. From the next clock on, all three flags are 0 and `irq` is 0, unless R8 applies.
- R8: A flag-setting event in the same cycle as `stat_rd` leaves that flag set after the read.
- R9: While `sw_reset` or `rtc_disable` is 1, the update-ended and periodic flags clear on the next clock and stay 0, and their set events are ignored. The alarm flag is unaffected.
- R10: While `supply_ok` is 0, the alarm flag clears on the next clock and `alarm_hit` cannot set it.
- R11: While `sw_reset` or `rtc_disable` is 1, the update-ended enable is masked, so `irq` drops in that same cycle if the update flag is its only enabled source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, asynchronous |
| sw_reset | input | 1 | Software RTC reset, holds the update-ended and periodic flags clear |
| rtc_disable | input | 1 | RTC disabled, same effect as sw_reset |
| upd_done | input | 1 | Time update finished strobe |
| alarm_hit | input | 1 | Alarm comparison match pulse |
| div_tap | input | 1 | Selected divider-chain tap level |
| upd_ie | input | 1 | Update-ended interrupt enable |
| alm_ie | input | 1 | Alarm interrupt enable |
| per_ie | input | 1 | Periodic interrupt enable |
| stat_rd | input | 1 | Status register read strobe, one cycle per read |
| supply_ok | input | 1 | Supply-valid bit, 0 means time and RAM contents are invalid |
| stat_rdata | output | 8 | Status value: bit 7 request, 6 periodic, 5 alarm, 4 update-ended, 3:0 zero |
| irq | output | 1 | Interrupt request pin, mirrors bit 7 |

## Verification
The bench builds the block with its defaults: a two-stage tap synchronizer and rising-edge detection. With these values the three-clock periodic latency can be pinned to an exact cycle. The bench can also show that a falling tap edge is ignored. It probes each clear source against each set source, including a set that lands in the same cycle as a read. It also checks that the update-ended enable mask removes the request in the very cycle that disable is raised.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

   // flag slots inside the flag bank
   localparam int FLG_UPD   = 0;
   localparam int FLG_ALM   = 1;
   localparam int FLG_PER   = 2;
   localparam int NUM_FLAGS = 3;

   // bit positions in the status read value (decoded by software)
   localparam int POS_IRQ   = 7;
   localparam int POS_PER   = 6;
   localparam int POS_ALM   = 5;
   localparam int POS_UPD   = 4;
   localparam int STAT_W    = 8;

   typedef enum logic [1:0] {
      EDGE_RISE = 2'd0,
      EDGE_FALL = 2'd1,
      EDGE_BOTH = 2'd2
   } edge_mode_e;

   typedef struct packed {
      logic per;
      logic alm;
      logic upd;
   } flag_vec_t;

endpackage

// File: rtl/rtc_tap_edge.sv
module rtc_tap_edge
   import rtc_irq_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter edge_mode_e MODE        = EDGE_RISE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tap_i,
   output logic pulse_o
);

   localparam int LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("rtc_tap_edge: SYNC_STAGES must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   tap_s;
   logic                   prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
      end else begin
         sync_q[0] <= tap_i;
         for (int i = 1; i < SYNC_STAGES; i++) begin
            sync_q[i] <= sync_q[i-1];
         end
      end
   end

   assign tap_s = sync_q[LAST];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= tap_s;
   end

   if (MODE == EDGE_RISE) begin : g_rise
      assign pulse_o = tap_s & ~prev_q;
      AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
         pulse_o |=> !pulse_o); // R4
   end else if (MODE == EDGE_FALL) begin : g_fall
      assign pulse_o = ~tap_s & prev_q;
      AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
         pulse_o |=> !pulse_o); // R4
   end else begin : g_both
      assign pulse_o = tap_s ^ prev_q;
   end

endmodule

// File: rtl/rtc_irq_flagbank.sv
module rtc_irq_flagbank #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] hold_i,
   input  logic         rd_i,
   output logic [N-1:0] q_o
);

   if (N < 1) begin : g_bad_n
      $error("rtc_irq_flagbank: N must be at least 1");
   end

   for (genvar k = 0; k < N; k++) begin : g_flag
      logic q;

      // priority: forced clear, then new event, then read clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         q <= 1'b0;
         else if (hold_i[k]) q <= 1'b0;
         else if (set_i[k])  q <= 1'b1;
         else if (rd_i)      q <= 1'b0;
      end

      assign q_o[k] = q;

      AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         hold_i[k] |=> !q_o[k]); // R9
      AST_SET_SURVIVES_READ: assert property (@(posedge clk) disable iff (!rst_n)
         (set_i[k] && !hold_i[k]) |=> q_o[k]); // R8
      AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_i && !set_i[k]) |=> !q_o[k]); // R7
   end

endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status
   import rtc_irq_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter edge_mode_e TAP_EDGE    = EDGE_RISE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_reset,
   input  logic              rtc_disable,
   input  logic              upd_done,
   input  logic              alarm_hit,
   input  logic              div_tap,
   input  logic              upd_ie,
   input  logic              alm_ie,
   input  logic              per_ie,
   input  logic              stat_rd,
   input  logic              supply_ok,
   output logic [STAT_W-1:0] stat_rdata,
   output logic              irq
);

   if (POS_IRQ >= STAT_W || POS_UPD < 4) begin : g_bad_layout
      $error("rtc_irq_status: status bit layout does not fit");
   end

   logic                 tap_pulse;
   logic                 rtc_off;
   logic                 upd_ie_eff;
   logic [NUM_FLAGS-1:0] set_vec;
   logic [NUM_FLAGS-1:0] hold_vec;
   logic [NUM_FLAGS-1:0] flag_q;
   flag_vec_t            flags;

   rtc_tap_edge #(
      .SYNC_STAGES (SYNC_STAGES),
      .MODE        (TAP_EDGE)
   ) u_tap_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .tap_i   (div_tap),
      .pulse_o (tap_pulse)
   );

   assign rtc_off = sw_reset | rtc_disable;

   always_comb begin
      set_vec           = '0;
      hold_vec          = '0;
      set_vec[FLG_UPD]  = upd_done;
      set_vec[FLG_ALM]  = alarm_hit;
      set_vec[FLG_PER]  = tap_pulse;
      hold_vec[FLG_UPD] = rtc_off;
      hold_vec[FLG_ALM] = ~supply_ok;
      hold_vec[FLG_PER] = rtc_off;
   end

   rtc_irq_flagbank #(
      .N (NUM_FLAGS)
   ) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec),
      .hold_i (hold_vec),
      .rd_i   (stat_rd),
      .q_o    (flag_q)
   );

   assign flags.upd = flag_q[FLG_UPD];
   assign flags.alm = flag_q[FLG_ALM];
   assign flags.per = flag_q[FLG_PER];

   assign upd_ie_eff = upd_ie & ~rtc_off;

   assign irq = (upd_ie_eff & flags.upd)
              | (alm_ie     & flags.alm)
              | (per_ie     & flags.per);

   always_comb begin
      stat_rdata          = '0;
      stat_rdata[POS_IRQ] = irq;
      stat_rdata[POS_PER] = flags.per;
      stat_rdata[POS_ALM] = flags.alm;
      stat_rdata[POS_UPD] = flags.upd;
   end

   AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (stat_rdata[POS_PER] | stat_rdata[POS_ALM] | stat_rdata[POS_UPD])); // R6
   AST_ALARM_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> !stat_rdata[POS_ALM]); // R10
   AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_reset || rtc_disable) |=> !(stat_rdata[POS_UPD] || stat_rdata[POS_PER])); // R9
   AST_OFF_MASKS_UPD: assert property (@(posedge clk) disable iff (!rst_n)
      ((sw_reset || rtc_disable) && !(alm_ie && stat_rdata[POS_ALM])
        && !(per_ie && stat_rdata[POS_PER])) |-> !irq); // R11
   AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |-> (stat_rdata[3:0] == 4'h0)); // R5

endmodule

// File: tb/rtc_irq_status_bench.sv
module rtc_irq_status_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sw_reset = 1'b0, rtc_disable = 1'b0;
   logic       upd_done = 1'b0, alarm_hit = 1'b0, div_tap = 1'b0;
   logic       upd_ie = 1'b0, alm_ie = 1'b0, per_ie = 1'b0;
   logic       stat_rd = 1'b0, supply_ok = 1'b1;
   logic [7:0] stat_rdata;
   logic       irq;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   logic [7:0] exp_q[$];
   string      req_q[$];

   always #4 clk = ~clk;

   rtc_irq_status u_rtc_irq_status (
      .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .rtc_disable(rtc_disable),
      .upd_done(upd_done), .alarm_hit(alarm_hit), .div_tap(div_tap),
      .upd_ie(upd_ie), .alm_ie(alm_ie), .per_ie(per_ie), .stat_rd(stat_rd),
      .supply_ok(supply_ok), .stat_rdata(stat_rdata), .irq(irq)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // driver: issue a status read and queue the value it must return
   task automatic rd(input logic [7:0] exp, input string req);
      exp_q.push_back(exp);
      req_q.push_back(req);
      stat_rd = 1'b1;
      tick();
      stat_rd = 1'b0;
   endtask

   task automatic pulse_upd();
      upd_done = 1'b1; tick(); upd_done = 1'b0;
   endtask

   task automatic pulse_alm();
      alarm_hit = 1'b1; tick(); alarm_hit = 1'b0;
   endtask

   // monitor: compare each read value against the scoreboard
   always @(negedge clk) begin
      #1;
      if (stat_rd) begin
         if (exp_q.size() == 0) begin
            checks++; failures++;
            $display("FAIL monitor actual=%h expected=none", stat_rdata);
         end else begin
            logic [7:0] e;
            string      r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            check(r, stat_rdata, e);
            check({r, " R5 low nibble"}, {4'h0, stat_rdata[3:0]}, 8'h00);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         failures++; checks++;
         $display("FAIL watchdog actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset rdata", stat_rdata, 8'h00);
      check("R1 reset irq", {7'd0, irq}, 8'h00);
      rst_n = 1'b1;
      tick();
      check("R1 after release", stat_rdata, 8'h00);

      // R2 update flag, enable off
      pulse_upd();
      check("R2 update flag bit4", stat_rdata, 8'h10);
      rd(8'h10, "R2 read update flag");
      check("R7 flags cleared after read", stat_rdata, 8'h00);

      // R6 update flag with enable
      upd_ie = 1'b1;
      pulse_upd();
      check("R6 irq from update", {7'd0, irq}, 8'h01);
      rd(8'h90, "R6 read with irq");
      check("R7 irq drops after read", {7'd0, irq}, 8'h00);

      // R3 alarm flag, masked then enabled
      pulse_alm();
      check("R6 masked alarm no irq", {7'd0, irq}, 8'h00);
      rd(8'h20, "R3 alarm flag bit5");
      alm_ie = 1'b1;
      pulse_alm();
      check("R6 irq from alarm", {7'd0, irq}, 8'h01);
      rd(8'hA0, "R3 alarm with irq");

      // R4 periodic flag from rising tap
      div_tap = 1'b1;
      tick(); tick();
      check("R4 not yet after 2 clocks", stat_rdata, 8'h00);
      tick();
      check("R4 periodic after 3 clocks", stat_rdata, 8'h40);
      rd(8'h40, "R4 read periodic");
      div_tap = 1'b0;
      repeat (5) tick();
      rd(8'h00, "R4 falling edge ignored");

      // R8 event in the read cycle
      upd_done = 1'b1;
      rd(8'h00, "R8 read returns pre-set value");
      upd_done = 1'b0;
      rd(8'h90, "R8 flag kept after read");

      // R9 / R11 disable
      alm_ie = 1'b0;
      pulse_upd();
      pulse_alm();
      div_tap = 1'b1;
      repeat (3) tick();
      check("R9 all flags set", stat_rdata, 8'hF0);
      rtc_disable = 1'b1;
      #1;
      check("R11 update enable masked", {7'd0, irq}, 8'h00);
      tick();
      rd(8'h20, "R9 disable clears update and periodic");
      pulse_upd();
      rd(8'h00, "R9 update ignored while disabled");
      rtc_disable = 1'b0;
      div_tap = 1'b0;
      pulse_upd();
      sw_reset = 1'b1;
      tick();
      sw_reset = 1'b0;
      rd(8'h00, "R9 software reset clears update");

      // R10 supply invalid
      supply_ok = 1'b0;
      pulse_alm();
      rd(8'h00, "R10 alarm ignored while invalid");
      supply_ok = 1'b1;
      pulse_alm();
      check("R10 alarm sets when valid", stat_rdata, 8'h20);
      supply_ok = 1'b0;
      tick();
      check("R10 alarm cleared when invalid", stat_rdata, 8'h00);
      supply_ok = 1'b1;

      tick(); tick();
      check("R7 scoreboard drained", 8'(exp_q.size()), 8'h00);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule